// File: doc/BRIEF.md
# Six-master locking bus arbiter

This block decides which of six bus masters owns a shared system bus. Each master drives a request line and a lock line. The arbiter also watches the bus-ready signal and a two-bit burst type. It publishes a one-hot grant vector and a binary owner index. It also drives a locked flag and a master-lock flag, which carry an indivisible transfer sequence through a handover. Two single-cycle strobes mark the internal events. The decide strobe marks the cycle in which a new grant is chosen. The start strobe marks the cycle in which ownership actually moves.

A grant is chosen by a round-robin search. The search begins just after the master that was granted last, and master 0 is the fallback when nobody is requesting. The newly granted master reaches the owner index on the next ready cycle, with a start strobe in the cycle after that ready cycle. The locked flag reaches the master-lock flag in the same step. A fixed four-beat burst loads a beat counter, and no new start is issued until that counter has run out. A flag also reports a lock line raised without its request line.

Top module: `lockbus_arbiter`

## Requirements
- R1: After reset, grant is 6'b000001, owner is 0, and locked, mastlock, start and decide are all 0.
- R2: busreq always equals the request line of the master whose number is on owner, where owner is the master number in plain binary with bit 0 least significant.
- R3: start is 1 only in a cycle whose previous cycle had ready high. After a start cycle whose burst input is 2'b01 (fixed four-beat burst), no start occurs until four further cycles with ready high have passed.
- R4: In the cycle after a cycle with ready high, owner equals the number of the master whose grant bit was set.
- R5: owner and mastlock change only in a cycle where start is 1. In the cycle after a cycle with ready high, mastlock equals the previous locked value.
- R6: grant and locked change only in the cycle after a cycle with decide high.
- R7: In the cycle after a decide, locked equals the lock line, as sampled in the decide cycle, of the master that is now granted.
- R8: In the cycle after a decide during which no request line was high, grant is 6'b000001 (master 0, the default master).
- R9: grant is always one-hot. After a decide, the granted master is the first requesting master found by counting upward from the previously granted master plus one, wrapping from 5 to 0. A master that was not requesting in the decide cycle is never picked unless no master was requesting.
- R10: proto_err is 1 exactly when some master has its lock line high while its request line is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 6 | Request line per master, bit i = master i |
| lock | input | 6 | Lock line per master, bit i = master i |
| burst | input | 2 | Burst type of the transfer being started; 2'b01 = fixed four beats |
| ready | input | 1 | Bus ready, high when the current beat completes |
| grant | output | 6 | One-hot grant vector |
| owner | output | 3 | Binary number of the current bus owner |
| locked | output | 1 | Granted master asked for a locked sequence |
| mastlock | output | 1 | Lock status of the current owner |
| start | output | 1 | Ownership handover strobe |
| decide | output | 1 | Arbitration strobe; grant may change in the next cycle |
| busreq | output | 1 | Request line of the current owner |
| proto_err | output | 1 | Lock raised without request on some master |

## Verification
The bench builds the arbiter with its default parameters: six masters and a four-beat fixed burst. With these values a full round-robin rotation fits in a few dozen cycles, and so does a complete burst hold-off window. The bench can therefore watch the pointer wrap from master 5 back to master 0, and it can watch a start being held back for exactly the counted ready beats. Ready is also held low while a new grant is pending, which shows that ownership and the lock flags stay frozen until the bus completes a beat.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;
  // Burst type codes seen on the burst input
  typedef enum logic [1:0] {
    BT_SINGLE = 2'b00,
    BT_FIX4   = 2'b01,
    BT_OPEN   = 2'b10,
    BT_OTHER  = 2'b11
  } burst_e;

  localparam logic [1:0] FIXED_BURST_CODE = BT_FIX4;
endpackage

// File: rtl/lockarb_rr_pick.sv
module lockarb_rr_pick #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] win
);
  // cyclic successor of base by step positions
  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base, input int unsigned step);
    int unsigned s;
    s = 32'(base) + step;
    if (s >= N) s = s - N;
    return s[IW-1:0];
  endfunction

  always_comb begin
    logic          found;
    logic [IW-1:0] cand;
    win   = '0;
    found = 1'b0;
    for (int unsigned k = 1; k <= N; k++) begin
      cand = wrap_add(ptr, k);
      if (!found && req[cand]) begin
        win   = cand;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockarb_burst_ctr.sv
module lockarb_burst_ctr #(
  parameter int unsigned BEATS = 4,
  parameter int unsigned CW    = 3,
  parameter logic [1:0]  FIXED = 2'b01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          start_q,
  input  logic [1:0]    burst,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_n
);
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur, input logic load, input logic rdy);
    if (load) return CW'(BEATS);
    if (rdy && cur != '0) return cur - 1'b1;
    return cur;
  endfunction

  logic load_fixed;
  assign load_fixed = start_q && (burst == FIXED);
  assign cnt_n      = next_count(cnt_q, load_fixed, ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R3: counter never exceeds the burst length
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BEATS));
endmodule

// File: rtl/lockarb_handover.sv
module lockarb_handover #(
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic [IW-1:0] gidx_q,
  input  logic          locked_q,
  input  logic          cnt_zero_n,
  output logic [IW-1:0] owner_q,
  output logic          mastlock_q,
  output logic          start_q,
  output logic [IW-1:0] owner_n,
  output logic          mastlock_n,
  output logic          start_n
);
  logic pending;
  assign pending    = (gidx_q != owner_q) || (locked_q != mastlock_q);
  assign owner_n    = ready ? gidx_q   : owner_q;
  assign mastlock_n = ready ? locked_q : mastlock_q;
  assign start_n    = ready && pending && cnt_zero_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= '0;
      mastlock_q <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      owner_q    <= owner_n;
      mastlock_q <= mastlock_n;
      start_q    <= start_n;
    end
  end

  // R5: owner and mastlock move only together with a start strobe
  a_r5_move_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(owner_q) || !$stable(mastlock_q)) |-> start_q);
  // R4: a ready cycle lands the granted master on the owner index
  a_r4_owner_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> owner_q == $past(gidx_q));
  // R5: a ready cycle carries locked into mastlock
  a_r5_mastlock_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> mastlock_q == $past(locked_q));
endmodule

// File: rtl/lockbus_arbiter.sv
module lockbus_arbiter #(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned BURST_BEATS = 4,
  parameter logic [1:0]  FIXED_CODE  = lockarb_pkg::FIXED_BURST_CODE
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         req,
  input  logic [NUM_MASTERS-1:0]         lock,
  input  logic [1:0]                     burst,
  input  logic                           ready,
  output logic [NUM_MASTERS-1:0]         grant,
  output logic [$clog2(NUM_MASTERS)-1:0] owner,
  output logic                           locked,
  output logic                           mastlock,
  output logic                           start,
  output logic                           decide,
  output logic                           busreq,
  output logic                           proto_err
);
  localparam int unsigned IW = $clog2(NUM_MASTERS);
  localparam int unsigned CW = $clog2(BURST_BEATS + 1);

  function automatic logic [NUM_MASTERS-1:0] to_onehot(input logic [IW-1:0] idx);
    logic [NUM_MASTERS-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // state of the decision side
  logic [IW-1:0] gidx_q, gidx_n;
  logic          locked_q, locked_n, decide_q, decide_n;

  // named internal events
  logic [IW-1:0] rr_win;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_zero_n, pend_n;
  logic [IW-1:0] owner_q, owner_n;
  logic          mastlock_q, mastlock_n, start_q, start_n;

  lockarb_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick (
    .req (req),
    .ptr (gidx_q),
    .win (rr_win)
  );

  lockarb_burst_ctr #(.BEATS(BURST_BEATS), .CW(CW), .FIXED(FIXED_CODE)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .start_q (start_q),
    .burst   (burst),
    .cnt_q   (cnt_q),
    .cnt_n   (cnt_n)
  );

  assign cnt_zero_n = (cnt_n == '0);

  lockarb_handover #(.IW(IW)) u_hand (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .gidx_q     (gidx_q),
    .locked_q   (locked_q),
    .cnt_zero_n (cnt_zero_n),
    .owner_q    (owner_q),
    .mastlock_q (mastlock_q),
    .start_q    (start_q),
    .owner_n    (owner_n),
    .mastlock_n (mastlock_n),
    .start_n    (start_n)
  );

  // a fresh decision is only taken when nothing is in flight
  assign gidx_n   = decide_q ? rr_win       : gidx_q;
  assign locked_n = decide_q ? lock[rr_win] : locked_q;
  assign pend_n   = (gidx_n != owner_n) || (locked_n != mastlock_n);
  assign decide_n = cnt_zero_n && !pend_n && !start_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gidx_q   <= '0;
      locked_q <= 1'b0;
      decide_q <= 1'b0;
    end else begin
      gidx_q   <= gidx_n;
      locked_q <= locked_n;
      decide_q <= decide_n;
    end
  end

  assign grant     = to_onehot(gidx_q);
  assign owner     = owner_q;
  assign locked    = locked_q;
  assign mastlock  = mastlock_q;
  assign start     = start_q;
  assign decide    = decide_q;
  assign busreq    = req[owner_q];
  assign proto_err = |(lock & ~req);

  // R3: start only after a ready cycle
  a_r3_start_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(ready));
  // R3: no start while a fixed burst is still counting
  a_r3_no_start_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> cnt_q == '0);
  // R6: grant and locked move only after decide
  a_r6_hold_without_decide: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_q |=> $stable(grant) && $stable(locked_q));
  // R7: locked reflects the lock line of the new grantee
  a_r7_lock_of_winner: assert property (@(posedge clk) disable iff (!rst_n)
    decide_q |=> locked_q == |($past(lock) & grant));
  // R8: idle decision falls back to master 0
  a_r8_default_master: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_q && req == '0) |=> grant == NUM_MASTERS'(1));
  // R9: grant stays one-hot
  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);
endmodule

// File: tb/tb_lockbus_arbiter.sv
module tb_lockbus_arbiter;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, lock = '0;
  logic [1:0] burst = 2'b00;
  logic ready = 1'b0;
  logic [N-1:0] grant;
  logic [2:0] owner;
  logic locked, mastlock, start, decide, busreq, proto_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  lockbus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .burst(burst), .ready(ready),
    .grant(grant), .owner(owner), .locked(locked), .mastlock(mastlock), .start(start),
    .decide(decide), .busreq(busreq), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pos_of(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int next_requester(input logic [N-1:0] r, input int last);
    for (int k = 1; k <= N; k++) if (r[(last + k) % N]) return (last + k) % N;
    return 0;
  endfunction

  // per-cycle monitor, sampled at the falling edge
  bit valid = 0;
  logic [N-1:0] p_req, p_lock, p_grant;
  logic [2:0] p_owner;
  logic p_ready, p_locked, p_mastlock, p_decide;
  int beats_left = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      valid = 0;
      beats_left = 0;
    end else begin
      chk(busreq == req[owner], "R2 busreq mirror", busreq, req[owner]);
      chk(proto_err == (|(lock & ~req)), "R10 proto_err", proto_err, |(lock & ~req));
      chk($countones(grant) == 1, "R9 onehot", grant, 1);
      if (valid) begin
        if (start) chk(p_ready, "R3 start after ready", p_ready, 1);
        if (start) chk(beats_left == 0, "R3 start inside burst", beats_left, 0);
        if (p_ready) chk(owner == pos_of(p_grant), "R4 owner follows grant", owner, pos_of(p_grant));
        if (!start) chk(owner == p_owner && mastlock == p_mastlock, "R5 hold without start",
                        {owner, mastlock}, {p_owner, p_mastlock});
        if (p_ready) chk(mastlock == p_locked, "R5 mastlock tracks locked", mastlock, p_locked);
        if (!p_decide) chk(grant == p_grant && locked == p_locked, "R6 hold without decide",
                           {grant, locked}, {p_grant, p_locked});
        if (p_decide) begin
          chk(locked == p_lock[pos_of(grant)], "R7 locked of winner", locked, p_lock[pos_of(grant)]);
          chk(pos_of(grant) == next_requester(p_req, pos_of(p_grant)), "R9 round robin",
              pos_of(grant), next_requester(p_req, pos_of(p_grant)));
          if (p_req == '0) chk(grant == 6'b000001, "R8 default master", grant, 1);
        end
      end
      if (start && burst == 2'b01) beats_left = 4;
      else if (ready && beats_left > 0) beats_left--;
      p_req = req; p_lock = lock; p_grant = grant; p_owner = owner;
      p_ready = ready; p_locked = locked; p_mastlock = mastlock; p_decide = decide;
      valid = 1;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // stimulus/expected vectors: {req, lock, burst, owner, locked}
  localparam logic [17:0] VEC [0:6] = '{
    {6'b000100, 6'b000000, 2'b00, 3'd2, 1'b0},
    {6'b100000, 6'b100000, 2'b00, 3'd5, 1'b1},
    {6'b000000, 6'b000000, 2'b00, 3'd0, 1'b0},
    {6'b001000, 6'b001000, 2'b01, 3'd3, 1'b1},
    {6'b000010, 6'b000000, 2'b01, 3'd1, 1'b0},
    {6'b000001, 6'b000001, 2'b00, 3'd0, 1'b1},
    {6'b010000, 6'b000000, 2'b00, 3'd4, 1'b0}
  };

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    chk(grant == 6'b000001, "R1 reset grant", grant, 1);
    chk(owner == 3'd0, "R1 reset owner", owner, 0);
    chk({locked, mastlock, start, decide} == 4'b0, "R1 reset flags",
        {locked, mastlock, start, decide}, 0);
    step(1);

    ready = 1'b1;
    for (int v = 0; v < 7; v++) begin
      req = VEC[v][17:12]; lock = VEC[v][11:6]; burst = VEC[v][5:4];
      step(14);
      #1;
      chk(owner == VEC[v][3:1], "R4 vector owner", owner, VEC[v][3:1]);
      chk(grant == (6'b1 << VEC[v][3:1]), "R9 vector grant", grant, 6'b1 << VEC[v][3:1]);
      chk(locked == VEC[v][0] && mastlock == VEC[v][0], "R7 vector lock flags",
          {locked, mastlock}, {VEC[v][0], VEC[v][0]});
      chk(busreq == (VEC[v][17:12] != 0), "R2 vector busreq", busreq, VEC[v][17:12] != 0);
      step(0);
      @(posedge clk); #1;
    end

    // ready low: a new grant waits, ownership frozen
    req = 6'b000100; lock = '0; burst = 2'b00;
    step(14);
    ready = 1'b0; req = 6'b010000;
    step(10); #1;
    chk(owner == 3'd2, "R5 owner frozen while not ready", owner, 2);
    chk(grant == 6'b010000, "R6 grant moved on decide", grant, 6'b010000);
    @(posedge clk); #1;
    ready = 1'b1;
    step(8); #1;
    chk(owner == 3'd4, "R4 owner after ready returns", owner, 4);
    @(posedge clk); #1;

    // round robin over all masters, wrapping
    begin
      int last, seen, guard;
      req = 6'b111111; burst = 2'b00;
      last = owner; seen = 0; guard = 0;
      while (seen < 8 && guard < 200) begin
        @(negedge clk);
        guard++;
        if (start) begin
          chk(owner == (last + 1) % N, "R9 rotation order", owner, (last + 1) % N);
          last = owner; seen++;
        end
      end
      chk(seen == 8, "R9 rotation progress", seen, 8);
    end

    // fixed burst spacing between starts
    begin
      int gap, mingap, starts;
      @(posedge clk); #1;
      burst = 2'b01; gap = 0; mingap = 1000; starts = 0;
      repeat (60) begin
        @(negedge clk);
        gap++;
        if (start) begin
          if (starts > 0 && gap < mingap) mingap = gap;
          starts++; gap = 0;
        end
      end
      chk(starts >= 3, "R3 starts during bursts", starts, 3);
      chk(mingap >= 5, "R3 burst hold-off", mingap, 5);
    end

    // lock without request
    @(posedge clk); #1;
    req = 6'b000000; lock = 6'b000100; #1;
    chk(proto_err == 1'b1, "R10 lock without request", proto_err, 1);
    req = 6'b000100; #1;
    chk(proto_err == 1'b0, "R10 lock with request", proto_err, 0);
    step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule